// File: doc/BRIEF.md
# Beam-position wait and skip comparator

This block decides when a display-list coprocessor may continue past a beam-position WAIT instruction, and whether a SKIP instruction should cause the following instruction to be dropped. It latches the two instruction words when the coprocessor hands over a WAIT or SKIP. It then compares the masked vertical and horizontal beam counters against the masked target position. Optionally, it also requires the blitter to be idle.

The blitter status is taken once, when the instruction is handed over, and taken again at evaluation time before the coprocessor commits to a blitter stall. A blitter that finished in the meantime therefore costs one re-evaluation slot and no stall. All decisions happen only in cycles where the coprocessor owns a bus slot. In every other cycle the machine holds its state, except the blitter stall, which ends as soon as the blitter is idle.

Top module: `copwait_cmp`

## Requirements
- R1: After a synchronous active-high reset, `idle` is 1 and `wait_release`, `skip_next` and `blit_wait` are 0.
- R2: The vertical mask is `{1, word2[14:8]}`, so beam bit 7 is always compared. The vertical target is `word1[15:8]` ANDed with that mask, and the current vertical value is `vbeam` ANDed with the same mask. The position is reached when the masked current vertical value is greater than the target, or when it is equal and the masked horizontal test of R3 holds.
- R3: The horizontal mask is `{word2[7:1], 0}`. The target is `word1[7:0]` ANDed with it, and the current value is the horizontal beam ANDed with it. The horizontal test holds when current >= target, so `word1[0]` and `word2[0]` never matter.
- R4: When `hbeam[0]` is 1, the value 0 replaces the horizontal beam in the comparison.
- R5: An instruction is accepted only when `idle`, `issue` and `can_read` are all 1. An evaluation happens only in a cycle with `can_read` = 1. Without `can_read`, nothing changes, apart from leaving the blitter stall (R7).
- R6: A WAIT evaluation that finds the condition met drives `wait_release` to 1 for exactly the next cycle, and `idle` returns to 1 in that same cycle. An unmet WAIT stays pending and is evaluated again in each later slot.
- R7: If `word2[15]` is 0 and `blit_busy` is 1 both when the WAIT is accepted and at its evaluation, `blit_wait` becomes 1 from the next cycle. It stays 1 while `blit_busy` is 1. After `blit_busy` falls it returns to 0, and the WAIT is evaluated on the beam alone in the next slot.
- R8: If the blitter was busy at acceptance but `blit_busy` is 0 at evaluation, `blit_wait` stays 0 and the WAIT is evaluated again on the beam alone in the next slot.
- R9: With `word2[15]` = 1, `blit_busy` has no effect on either instruction.
- R10: A SKIP (`issue_skip` = 1) is evaluated once and then `idle` returns to 1. `skip_next` is set if the beam position is reached and the blitter was not seen busy with `word2[15]` = 0 at acceptance; otherwise `skip_next` is left unchanged. `skip_clear` clears `skip_next`, and setting wins if both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| can_read | input | 1 | Coprocessor owns a bus slot this cycle |
| issue | input | 1 | A WAIT or SKIP is handed over with its two words |
| issue_skip | input | 1 | 1 = SKIP, 0 = WAIT |
| word1 | input | 16 | First instruction word (target position) |
| word2 | input | 16 | Second instruction word (masks, bit 15 = ignore blitter) |
| vbeam | input | 8 | Vertical beam counter, low bits |
| hbeam | input | 8 | Horizontal beam counter |
| blit_busy | input | 1 | Blitter busy status |
| skip_clear | input | 1 | Next instruction consumed, clears skip flag |
| wait_release | output | 1 | One-cycle strobe: WAIT condition met |
| skip_next | output | 1 | Next instruction is to be ignored |
| blit_wait | output | 1 | Stalled waiting for the blitter |
| idle | output | 1 | In the instruction-read state |

## Verification
Two events can fall in the same cycle: the blitter going idle and the coprocessor slot in which a gated WAIT is evaluated. The bench sets `blit_busy` at acceptance and drops it exactly in the evaluation cycle. The reference model must then show no blitter stall and a beam-only re-evaluation one slot later. A second collision, `skip_clear` in the cycle where a SKIP hit sets the flag, is provoked as well and judged against the rule that setting wins.

// File: rtl/copwait_pkg.sv
package copwait_pkg;
  localparam int CMP_W  = 8;
  localparam int WORD_W = 2 * CMP_W;

  typedef enum logic [1:0] {
    CW_READ    = 2'd0,
    CW_WEVAL   = 2'd1,
    CW_SEVAL   = 2'd2,
    CW_BLTWAIT = 2'd3
  } cw_state_t;

  // Odd horizontal positions compare as zero.
  function automatic logic [CMP_W-1:0] h_effective(input logic [CMP_W-1:0] h);
    return h[0] ? '0 : h;
  endfunction

  // Masked beam-position test: vertical bit 7 forced into the mask, horizontal bit 0 excluded.
  function automatic logic pos_reached(input logic [CMP_W-1:0] v,
                                       input logic [CMP_W-1:0] h,
                                       input logic [WORD_W-1:0] w1,
                                       input logic [WORD_W-1:0] w2);
    logic [CMP_W-1:0] vmask, hmask, vtgt, vnow, htgt, hnow;
    vmask = {1'b1, w2[WORD_W-2:CMP_W]};
    hmask = {w2[CMP_W-1:1], 1'b0};
    vtgt  = w1[WORD_W-1:CMP_W] & vmask;
    vnow  = v & vmask;
    htgt  = w1[CMP_W-1:0] & hmask;
    hnow  = h_effective(h) & hmask;
    return (vnow > vtgt) || ((vnow == vtgt) && (hnow >= htgt));
  endfunction
endpackage

// File: rtl/beam_match.sv
module beam_match
  import copwait_pkg::*;
(
  input  logic [CMP_W-1:0]  vbeam,
  input  logic [CMP_W-1:0]  hbeam,
  input  logic [WORD_W-1:0] w1,
  input  logic [WORD_W-1:0] w2,
  output logic              reached
);
  always_comb reached = pos_reached(vbeam, hbeam, w1, w2);
endmodule

// File: rtl/cw_fsm.sv
module cw_fsm
  import copwait_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic can_read,
  input  logic issue,
  input  logic issue_skip,
  input  logic issue_gate,
  input  logic blit_busy,
  input  logic reached,
  input  logic skip_clear,
  output logic accept,
  output logic wait_release,
  output logic skip_next,
  output logic blit_wait,
  output logic idle
);
  cw_state_t state;
  logic      sampled;

  // named events for the assertions
  logic recheck_drop, commit_blt, wait_hit, skip_hit, seval_slot;

  assign accept       = (state == CW_READ) && can_read && issue;
  assign recheck_drop = (state == CW_WEVAL) && can_read && sampled && !blit_busy;
  assign commit_blt   = (state == CW_WEVAL) && can_read && sampled && blit_busy;
  assign wait_hit     = (state == CW_WEVAL) && can_read && !sampled && reached;
  assign seval_slot   = (state == CW_SEVAL) && can_read;
  assign skip_hit     = seval_slot && reached && !sampled;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= CW_READ;
      sampled      <= 1'b0;
      wait_release <= 1'b0;
      skip_next    <= 1'b0;
    end else begin
      wait_release <= wait_hit;
      if (skip_clear) skip_next <= 1'b0;
      if (skip_hit)   skip_next <= 1'b1;
      case (state)
        CW_READ: if (accept) begin
          sampled <= issue_gate & blit_busy;
          state   <= issue_skip ? CW_SEVAL : CW_WEVAL;
        end
        CW_WEVAL: begin
          if (commit_blt)        state   <= CW_BLTWAIT;
          else if (recheck_drop) sampled <= 1'b0;
          else if (wait_hit)     state   <= CW_READ;
        end
        CW_SEVAL: if (seval_slot) begin
          sampled <= 1'b0;
          state   <= CW_READ;
        end
        CW_BLTWAIT: if (!blit_busy) begin
          sampled <= 1'b0;
          state   <= CW_WEVAL;
        end
        default: state <= CW_READ;
      endcase
    end
  end

  assign idle      = (state == CW_READ);
  assign blit_wait = (state == CW_BLTWAIT);

  // R6
  release_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wait_release |-> idle);
  // R7
  blt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (blit_wait && blit_busy) |=> blit_wait);
  // R8
  recheck_chk: assert property (@(posedge clk) disable iff (rst)
    recheck_drop |=> (!blit_wait && state == CW_WEVAL));
  // R5
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!can_read && state != CW_BLTWAIT) |=> $stable(state));
  // R10
  skip_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(skip_next) |-> $past(state == CW_SEVAL));
endmodule

// File: rtl/copwait_cmp.sv
module copwait_cmp
  import copwait_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              can_read,
  input  logic              issue,
  input  logic              issue_skip,
  input  logic [WORD_W-1:0] word1,
  input  logic [WORD_W-1:0] word2,
  input  logic [CMP_W-1:0]  vbeam,
  input  logic [CMP_W-1:0]  hbeam,
  input  logic              blit_busy,
  input  logic              skip_clear,
  output logic              wait_release,
  output logic              skip_next,
  output logic              blit_wait,
  output logic              idle
);
  logic [WORD_W-1:0] w1_q, w2_q;
  logic              accept, reached;

  always_ff @(posedge clk) begin
    if (rst) begin
      w1_q <= '0;
      w2_q <= '0;
    end else if (accept) begin
      w1_q <= word1;
      w2_q <= word2;
    end
  end

  beam_match u_match (
    .vbeam  (vbeam),
    .hbeam  (hbeam),
    .w1     (w1_q),
    .w2     (w2_q),
    .reached(reached)
  );

  cw_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .can_read    (can_read),
    .issue       (issue),
    .issue_skip  (issue_skip),
    .issue_gate  (~word2[WORD_W-1]),
    .blit_busy   (blit_busy),
    .reached     (reached),
    .skip_clear  (skip_clear),
    .accept      (accept),
    .wait_release(wait_release),
    .skip_next   (skip_next),
    .blit_wait   (blit_wait),
    .idle        (idle)
  );
endmodule

// File: tb/test_copwait_cmp.sv
module test_copwait_cmp;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic can_read = 1'b0, issue = 1'b0, issue_skip = 1'b0, blit_busy = 1'b0, skip_clear = 1'b0;
  logic [15:0] word1 = '0, word2 = '0;
  logic [7:0]  vbeam = '0, hbeam = '0;
  logic wait_release, skip_next, blit_wait, idle;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  copwait_cmp i_copwait_cmp (
    .clk(clk), .rst(rst), .can_read(can_read), .issue(issue), .issue_skip(issue_skip),
    .word1(word1), .word2(word2), .vbeam(vbeam), .hbeam(hbeam), .blit_busy(blit_busy),
    .skip_clear(skip_clear), .wait_release(wait_release), .skip_next(skip_next),
    .blit_wait(blit_wait), .idle(idle)
  );

  // Reference model. Phase: 0 ready, 1 wait pending, 2 skip pending, 3 blitter stall.
  int m_phase = 0, m_saw_busy = 0, m_rel = 0, m_skip = 0;
  int t1 = 0, t2 = 0;

  function automatic int ref_hit(int v, int h, int a, int b);
    int vm, hm, hh;
    vm = 128 + ((b / 256) % 128);
    hm = (b % 256) - (b % 2);
    hh = (h % 2 == 1) ? 0 : h;
    if ((v & vm) > ((a / 256) & vm)) return 1;
    if ((v & vm) < ((a / 256) & vm)) return 0;
    return ((hh & hm) >= ((a % 256) & hm)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_saw_busy = 0; m_rel = 0; m_skip = 0;
    end else begin
      int hit;
      hit = ref_hit(int'(vbeam), int'(hbeam), t1, t2);
      m_rel = 0;
      if (skip_clear) m_skip = 0;
      if (m_phase == 0) begin
        if (can_read && issue) begin
          t1 = int'(word1); t2 = int'(word2);
          m_saw_busy = (word2[15] == 1'b0 && blit_busy) ? 1 : 0;
          m_phase = issue_skip ? 2 : 1;
        end
      end else if (m_phase == 1) begin
        if (can_read) begin
          if (m_saw_busy == 1) begin
            if (blit_busy) m_phase = 3; else m_saw_busy = 0;
          end else if (hit == 1) begin
            m_rel = 1; m_phase = 0;
          end
        end
      end else if (m_phase == 2) begin
        if (can_read) begin
          if (hit == 1 && m_saw_busy == 0) m_skip = 1;
          m_saw_busy = 0; m_phase = 0;
        end
      end else begin
        if (!blit_busy) begin m_saw_busy = 0; m_phase = 1; end
      end
    end
  end

  task automatic chk(string nm, logic act, int exp);
    checks++;
    if (int'(act) != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, nm, act, exp, $time);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      chk("wait_release", wait_release, m_rel);
      chk("skip_next", skip_next, m_skip);
      chk("blit_wait", blit_wait, (m_phase == 3) ? 1 : 0);
      chk("idle", idle, (m_phase == 0) ? 1 : 0);
      issue = 1'b0; skip_clear = 1'b0;
    end
  endtask

  task automatic give(logic sk, logic [15:0] a, logic [15:0] b);
    issue = 1'b1; issue_skip = sk; word1 = a; word2 = b;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0; can_read = 1'b1;
    // R1 reset state
    cur_req = "R1";
    chk("idle", idle, 1); chk("wait_release", wait_release, 0);
    chk("skip_next", skip_next, 0); chk("blit_wait", blit_wait, 0);

    // R6 WAIT released when horizontal reaches target
    cur_req = "R6";
    vbeam = 8'h20; hbeam = 8'h30;
    give(1'b0, 16'h2040, 16'hFFFE); cyc(3);
    hbeam = 8'h40; cyc(3);

    // R2 vertical bit 7 cannot be masked away
    cur_req = "R2";
    vbeam = 8'h7F; hbeam = 8'h00;
    give(1'b0, 16'h9000, 16'h80FE); cyc(3);
    vbeam = 8'hFF; hbeam = 8'h02; cyc(1);
    vbeam = 8'h80; cyc(2);
    // R2 masked-off vertical bits ignored, greater vertical wins over horizontal
    vbeam = 8'h33; hbeam = 8'h00;
    give(1'b0, 16'h30FE, 16'h83FE); cyc(3);

    // R3 low horizontal bit excluded
    cur_req = "R3";
    vbeam = 8'h00; hbeam = 8'h40;
    give(1'b0, 16'h0041, 16'hFFFF); cyc(3);

    // R4 odd horizontal counts as zero
    cur_req = "R4";
    hbeam = 8'h41;
    give(1'b0, 16'h0040, 16'hFFFE); cyc(3);
    hbeam = 8'h42; cyc(2);

    // R5 nothing happens without a slot
    cur_req = "R5";
    can_read = 1'b0; hbeam = 8'h00;
    give(1'b0, 16'h0000, 16'hFFFE); issue = 1'b1;
    cyc(1); issue = 1'b1; cyc(1); issue = 1'b1;
    can_read = 1'b1; cyc(1);
    can_read = 1'b0; cyc(3);
    can_read = 1'b1; cyc(2);

    // R7 blitter busy at acceptance and at evaluation -> stall
    cur_req = "R7";
    blit_busy = 1'b1;
    give(1'b0, 16'h0000, 16'h7FFE); cyc(1);
    cyc(4);
    can_read = 1'b0; blit_busy = 1'b0; cyc(1);
    cyc(1); can_read = 1'b1; cyc(2);

    // R8 blitter finishes exactly in the evaluation slot
    cur_req = "R8";
    blit_busy = 1'b1;
    give(1'b0, 16'h0000, 16'h7FFE); cyc(1);
    blit_busy = 1'b0; cyc(1);
    cyc(2);

    // R9 ignore-blitter bit set
    cur_req = "R9";
    blit_busy = 1'b1;
    give(1'b0, 16'h0000, 16'hFFFE); cyc(3);
    give(1'b1, 16'h0000, 16'hFFFE); cyc(2);
    skip_clear = 1'b1; cyc(1);
    blit_busy = 1'b0;

    // R10 SKIP hit, miss, gated miss, clear, and clear colliding with set
    cur_req = "R10";
    vbeam = 8'h20;
    give(1'b1, 16'h1000, 16'hFFFE); cyc(3);
    skip_clear = 1'b1; cyc(1);
    vbeam = 8'h05;
    give(1'b1, 16'h1000, 16'hFFFE); cyc(3);
    blit_busy = 1'b1; vbeam = 8'h20;
    give(1'b1, 16'h1000, 16'h7FFE); cyc(3);
    blit_busy = 1'b0;
    give(1'b1, 16'h1000, 16'hFFFE); cyc(1);
    skip_clear = 1'b1; cyc(1);
    cyc(2);

    // R1 reset mid-instruction
    cur_req = "R1";
    give(1'b0, 16'hFF00, 16'hFFFE); cyc(1);
    rst = 1'b1; cyc(1); rst = 1'b0;
    chk("idle", idle, 1); chk("skip_next", skip_next, 0);
    cyc(2);
    finish_run();
  end
endmodule